// File: doc/BRIEF.md
# Video Sync Short-Packet Generator

This block sits between a display controller's video timing outputs and a display-serial-interface packet engine. It watches the vertical and horizontal sync lines, finds their active and inactive edges, and turns them into requests for synchronization short packets. Each request carries a 24-bit packet header. The low byte holds a virtual channel and a 6-bit data type. The two upper bytes are zero because sync packets carry no payload. A downstream ECC and lane stage consumes these requests through a valid/ready handshake.

A vertical sync edge never produces a packet at the moment it occurs. The edge is remembered as a pending event, and the next horizontal sync activation sends the vertical code in place of its own horizontal start code. After reset, the block discards everything it sees until vertical sync becomes active for the first time. Because of the pending mechanism, that first vertical sync takes the place of the horizontal sync of the first line. Four enable bits select which sync events are turned into packets. A small queue absorbs back-pressure, and a sticky flag reports any request that is lost.

Top module: `syncpkt_gen`

## Requirements
- R1: After reset, `pkt_valid_o` and `ovf_o` are both 0.
- R2: Polarity: `vs_pol_i`/`hs_pol_i` = 1 means the line is active high and 0 means active low.
  - Edges are found by comparing the active level with a registered copy that resets to inactive.
  - When the queue is empty, a request caused by an edge becomes visible on `pkt_valid_o` right after the first rising clock edge that samples the new level.
- R3: Header layout and codes.
  - `pkt_hdr_o[7:6]` is the virtual channel and `pkt_hdr_o[5:0]` is the data type.
  - `pkt_hdr_o[23:8]` is always zero.
  - Data types: vertical start = 0x01, vertical end = 0x11, horizontal start = 0x21, horizontal end = 0x31.
- R4: Until vertical sync becomes active for the first time after reset, no edge of either line produces a request. This includes a vertical deactivation.
- R5: Once synchronized, a horizontal activation queues a horizontal start request and a horizontal deactivation queues a horizontal end request, each only if its enable bit is set.
- R6: Vertical edges and pending events.
  - A vertical activation or deactivation queues nothing itself. It records a pending start or end event, and a later vertical edge overwrites an unused one.
  - The next horizontal activation sends the pending vertical code instead of a horizontal start and clears the pending event.
  - If that activation falls in the same cycle as a new vertical edge, it consumes the older pending event and the new edge becomes pending.
- R7: If the pending vertical event's enable bit is clear at the horizontal activation that consumes it, that activation sends a horizontal start if that is enabled, and nothing otherwise.
- R8: `evt_en_i` bit 0 enables vertical start, bit 1 vertical end, bit 2 horizontal start and bit 3 horizontal end. The bits are sampled in the cycle in which the request is decided.
- R9: Requests leave in arrival order through a queue of `DEPTH` entries. `pkt_valid_o` and `pkt_hdr_o` hold steady until `pkt_ready_i` is seen high.
- R10: Overflow and the error flag.
  - A request that finds the queue full, with no entry leaving in that cycle, is dropped and sets `ovf_o`.
  - `ovf_o` stays set until a cycle with `err_clr_i` high clears it.
  - A new overflow in that same cycle wins over the clear.
- R11: `vc_i` is sampled into the header in the cycle in which the request is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vs_pol_i | input | 1 | Vertical sync active level (1 = high) |
| hs_pol_i | input | 1 | Horizontal sync active level (1 = high) |
| vsync_i | input | 1 | Vertical sync from the display controller |
| hsync_i | input | 1 | Horizontal sync from the display controller |
| evt_en_i | input | 4 | Per-event enables: vertical start, vertical end, horizontal start, horizontal end (bit 0 to bit 3) |
| vc_i | input | VC_W (2) | Virtual channel placed in headers |
| err_clr_i | input | 1 | Clears the overflow flag |
| pkt_valid_o | output | 1 | Header request valid |
| pkt_ready_i | input | 1 | Downstream accepts the header |
| pkt_hdr_o | output | VC_W+22 (24) | Short-packet header: data bytes in bits 23:8, identifier in bits 7:0 |
| ovf_o | output | 1 | Sticky request-lost flag |

## Verification
On every cycle, the checker enforces the following:
- a held request stays unchanged while it is not accepted;
- the payload bytes stay zero and only the four legal data types appear;
- nothing is offered before the first vertical activation;
- the error flag stays set until it is cleared.

Only the bench's reference model, run over directed and pseudo-random sync patterns, can show the rest:
- a vertical code replacing exactly the following horizontal start;
- the fallback when a pending event is disabled;
- polarity handling;
- which request is dropped on overflow.

// File: rtl/syncpkt_pkg.sv
package syncpkt_pkg;

    localparam int DT_W  = 6;
    localparam int PAY_W = 16;
    localparam int N_EV  = 4;

    // Event kinds; the enum value is also the enable bit index.
    typedef enum logic [1:0] {
        EV_VS_START = 2'd0,
        EV_VS_END   = 2'd1,
        EV_HS_START = 2'd2,
        EV_HS_END   = 2'd3
    } sync_ev_e;

    // Vertical event waiting for the next horizontal activation.
    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_START = 2'd1,
        PEND_END   = 2'd2
    } pend_e;

    function automatic logic [DT_W-1:0] ev_code(input sync_ev_e ev);
        logic [DT_W-1:0] code;
        case (ev)
            EV_VS_START: code = 6'h01;
            EV_VS_END:   code = 6'h11;
            EV_HS_START: code = 6'h21;
            default:     code = 6'h31;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_i,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        act;

    always_comb begin
        act       = pol_i ? sig_i : ~sig_i;
        st_d      = st_q;
        st_d.lvl  = act;
        rise_o    = act & ~st_q.lvl;
        fall_o    = ~act & st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sync_evt_seq.sv
module sync_evt_seq
    import syncpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_rise_i,
    input  logic              vs_fall_i,
    input  logic              hs_rise_i,
    input  logic              hs_fall_i,
    input  logic [N_EV-1:0]   en_i,
    output logic              push_o,
    output sync_ev_e          ev_o,
    output logic              synced_o
);

    typedef struct packed {
        logic  synced;
        pend_e pend;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        push_o = 1'b0;
        ev_o   = EV_HS_START;

        if (st_q.synced) begin
            if (hs_rise_i) begin
                // A pending vertical event replaces this horizontal start.
                case (st_q.pend)
                    PEND_START: begin
                        if (en_i[EV_VS_START]) begin
                            push_o = 1'b1;
                            ev_o   = EV_VS_START;
                        end else if (en_i[EV_HS_START]) begin
                            push_o = 1'b1;
                        end
                    end
                    PEND_END: begin
                        if (en_i[EV_VS_END]) begin
                            push_o = 1'b1;
                            ev_o   = EV_VS_END;
                        end else if (en_i[EV_HS_START]) begin
                            push_o = 1'b1;
                        end
                    end
                    default: begin
                        push_o = en_i[EV_HS_START];
                    end
                endcase
                st_d.pend = PEND_NONE;
            end else if (hs_fall_i) begin
                push_o = en_i[EV_HS_END];
                ev_o   = EV_HS_END;
            end
        end

        // New vertical edges become pending after any consumption above.
        if (vs_rise_i) begin
            st_d.synced = 1'b1;
            st_d.pend   = PEND_START;
        end else if (vs_fall_i && st_q.synced) begin
            st_d.pend   = PEND_END;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{synced: 1'b0, pend: PEND_NONE};
        else        st_q <= st_d;
    end

    assign synced_o = st_q.synced;

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] dout_o,
    output logic         ovf_evt_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        pop;
    logic        accept;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        pop       = (st_q.cnt != '0) && ready_i;
        accept    = push_i && ((st_q.cnt != CW'(DEPTH)) || pop);
        ovf_evt_o = push_i && !accept;
        if (accept) begin
            st_d.mem[st_q.wr] = din_i;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(accept) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = (st_q.cnt != '0);
    assign dout_o  = st_q.mem[st_q.rd];

endmodule

// File: rtl/syncpkt_gen.sv
module syncpkt_gen
    import syncpkt_pkg::*;
#(
    parameter int VC_W  = 2,
    parameter int DEPTH = 4,
    localparam int HDR_W = PAY_W + VC_W + DT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_pol_i,
    input  logic             hs_pol_i,
    input  logic             vsync_i,
    input  logic             hsync_i,
    input  logic [N_EV-1:0]  evt_en_i,
    input  logic [VC_W-1:0]  vc_i,
    input  logic             err_clr_i,
    output logic             pkt_valid_o,
    input  logic             pkt_ready_i,
    output logic [HDR_W-1:0] pkt_hdr_o,
    output logic             ovf_o
);

    localparam int N_LINES = 2;   // index 0: vertical, 1: horizontal

    typedef struct packed {
        logic ovf;
    } top_state_t;

    logic [N_LINES-1:0] line_pol;
    logic [N_LINES-1:0] line_sig;
    logic [N_LINES-1:0] line_rise;
    logic [N_LINES-1:0] line_fall;

    assign line_pol = {hs_pol_i, vs_pol_i};
    assign line_sig = {hsync_i, vsync_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_edge
        sync_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pol_i  (line_pol[g]),
            .sig_i  (line_sig[g]),
            .rise_o (line_rise[g]),
            .fall_o (line_fall[g])
        );
    end

    logic       seq_push;
    sync_ev_e   seq_ev;
    logic       seq_synced;

    sync_evt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vs_rise_i (line_rise[0]),
        .vs_fall_i (line_fall[0]),
        .hs_rise_i (line_rise[1]),
        .hs_fall_i (line_fall[1]),
        .en_i      (evt_en_i),
        .push_o    (seq_push),
        .ev_o      (seq_ev),
        .synced_o  (seq_synced)
    );

    logic [HDR_W-1:0] hdr_in;
    logic             ovf_evt;

    assign hdr_in = {{PAY_W{1'b0}}, vc_i, ev_code(seq_ev)};

    pkt_fifo #(
        .DEPTH (DEPTH),
        .W     (HDR_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (seq_push),
        .din_i     (hdr_in),
        .ready_i   (pkt_ready_i),
        .valid_o   (pkt_valid_o),
        .dout_o    (pkt_hdr_o),
        .ovf_evt_o (ovf_evt)
    );

    top_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = (st_q.ovf && !err_clr_i) || ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/syncpkt_gen_chk.sv
module syncpkt_gen_chk #(
    parameter int HDR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid_o,
    input logic             pkt_ready_i,
    input logic [HDR_W-1:0] pkt_hdr_o,
    input logic             ovf_o,
    input logic             err_clr_i,
    input logic             synced
);

    // R9
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_hdr_o));

    // R3
    zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> pkt_hdr_o[HDR_W-1:8] == '0);

    // R3
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> (pkt_hdr_o[5:0] == 6'h01 || pkt_hdr_o[5:0] == 6'h11 ||
                         pkt_hdr_o[5:0] == 6'h21 || pkt_hdr_o[5:0] == 6'h31));

    // R4
    presync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !pkt_valid_o);

    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !err_clr_i |=> ovf_o);

endmodule

bind syncpkt_gen syncpkt_gen_chk #(.HDR_W(HDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid_o (pkt_valid_o),
    .pkt_ready_i (pkt_ready_i),
    .pkt_hdr_o   (pkt_hdr_o),
    .ovf_o       (ovf_o),
    .err_clr_i   (err_clr_i),
    .synced      (seq_synced)
);

// File: tb/syncpkt_gen_tb_top.sv
`timescale 1ns/1ps
module syncpkt_gen_tb_top;

    localparam int DEPTH = 4;
    localparam int VC_W  = 2;
    localparam int HDR_W = 16 + VC_W + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vs_pol = 1'b1, hs_pol = 1'b1;
    logic vact = 1'b0, hact = 1'b0;
    logic [3:0] en = 4'hF;
    logic [VC_W-1:0] vc = '0;
    logic err_clr = 1'b0;
    logic ready = 1'b1;
    logic vsync, hsync;
    logic pkt_valid, ovf;
    logic [HDR_W-1:0] hdr;

    assign vsync = vs_pol ? vact : ~vact;
    assign hsync = hs_pol ? hact : ~hact;

    always #4 clk = ~clk;

    syncpkt_gen #(.VC_W(VC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .vs_pol_i(vs_pol), .hs_pol_i(hs_pol),
        .vsync_i(vsync), .hsync_i(hsync), .evt_en_i(en), .vc_i(vc),
        .err_clr_i(err_clr), .pkt_valid_o(pkt_valid), .pkt_ready_i(ready),
        .pkt_hdr_o(hdr), .ovf_o(ovf)
    );

    // Behavioural reference model
    int    mq[$];
    bit    m_vs, m_hs, m_sync, m_ovf;
    int    m_pend;   // 0 none, 1 vertical start, 2 vertical end

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_vs = 0; m_hs = 0; m_sync = 0; m_ovf = 0; m_pend = 0;
        end else begin
            bit va, ha, do_push, do_pop, drop;
            int code;
            va = vs_pol ? vsync : !vsync;
            ha = hs_pol ? hsync : !hsync;
            do_push = 0; code = 0; drop = 0;
            do_pop = (mq.size() > 0) && ready;
            if (m_sync && ha && !m_hs) begin
                if (m_pend == 1 && en[0]) begin do_push = 1; code = 'h01; end
                else if (m_pend == 2 && en[1]) begin do_push = 1; code = 'h11; end
                else if (en[2]) begin do_push = 1; code = 'h21; end
                m_pend = 0;
            end else if (m_sync && !ha && m_hs && en[3]) begin
                do_push = 1; code = 'h31;
            end
            if (va && !m_vs) begin m_sync = 1; m_pend = 1; end
            else if (!va && m_vs && m_sync) m_pend = 2;
            if (do_pop) void'(mq.pop_front());
            if (do_push) begin
                if (mq.size() < DEPTH) mq.push_back((int'(vc) << 6) | code);
                else drop = 1;
            end
            m_ovf = (m_ovf && !err_clr) || drop;
            m_vs = va; m_hs = ha;
        end
    end

    int checks = 0, errors = 0;
    string cur = "R1";
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit ev = mq.size() > 0;
        chk(pkt_valid == ev, cur, "valid (R9)", pkt_valid, ev);
        if (ev && pkt_valid)
            chk(hdr == HDR_W'(mq[0]), cur, "header (R3)", hdr, mq[0]);
        chk(ovf == m_ovf, cur, "ovf (R10)", ovf, m_ovf);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (rst_n) compare();
        end
    endtask

    task automatic hpulse(input int w, input int gap);
        hact = 1'b1; step(w);
        hact = 1'b0; step(gap);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        chk(pkt_valid == 0, "R1", "reset valid", pkt_valid, 0);
        chk(ovf == 0, "R1", "reset ovf", ovf, 0);

        cur = "R4";
        repeat (3) hpulse(2, 3);
        chk(pkt_valid == 0, "R4", "pre-sync valid", pkt_valid, 0);

        cur = "R6";
        vact = 1'b1; step(3);
        chk(pkt_valid == 0, "R6", "vertical edge alone", pkt_valid, 0);
        hact = 1'b1; ready = 1'b0; step(1);
        chk(pkt_valid == 1, "R2", "one-edge latency", pkt_valid, 1);
        chk(hdr[5:0] == 6'h01, "R6", "replaced code", hdr[5:0], 6'h01);
        ready = 1'b1; step(2); hact = 1'b0; step(3);
        hpulse(2, 3);
        vact = 1'b0; step(2);
        hpulse(2, 3); hpulse(2, 3);

        cur = "R7";
        en = 4'b1110; vact = 1'b1; step(2); hpulse(2, 3);
        vact = 1'b0; step(2); hpulse(2, 3);
        en = 4'b1010; vact = 1'b1; step(2); hpulse(2, 3); hpulse(2, 3);
        vact = 1'b0; step(2); hpulse(2, 3);

        cur = "R5";
        en = 4'b1100; repeat (3) hpulse(1, 2);

        cur = "R8";
        en = 4'b0001; vact = 1'b1; step(2); hpulse(2, 2); vact = 1'b0; step(2); hpulse(2, 2);
        en = 4'b1000; hpulse(2, 2);
        en = 4'hF;

        cur = "R2";
        vs_pol = 1'b0; hs_pol = 1'b0; step(2);
        vact = 1'b1; step(2); hpulse(2, 2); vact = 1'b0; step(2); hpulse(2, 2);
        vs_pol = 1'b1; hs_pol = 1'b1; step(2);

        cur = "R11";
        for (int i = 0; i < 4; i++) begin
            vc = VC_W'(i); hpulse(1, 2);
        end

        cur = "R10";
        ready = 1'b0;
        repeat (4) hpulse(1, 1);
        chk(ovf == 1, "R10", "flag after drop", ovf, 1);
        ready = 1'b1; step(6);
        chk(ovf == 1, "R10", "flag sticky", ovf, 1);
        err_clr = 1'b1; step(1); err_clr = 1'b0; step(1);
        chk(ovf == 0, "R10", "flag cleared", ovf, 0);

        cur = "R9";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 29) == 0) vact = ~vact;
            if ($urandom_range(0, 4) == 0) hact = ~hact;
            ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 63) == 0) en = 4'($urandom);
            if ($urandom_range(0, 31) == 0) vc = VC_W'($urandom);
            err_clr = ($urandom_range(0, 99) == 0);
            step(1);
        end
        err_clr = 1'b0; ready = 1'b1; step(10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule